// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

This block is a parameterised N-bit datapath unit that combines a ripple-carry adder, a bitwise logic unit and a one-place shifter behind a single per-bit output selector. Two operands, a four-bit function select and a carry input choose one of fourteen micro-operations. The result and the adder's final carry come out combinationally in the same cycle the inputs are applied.

A destination register is built in. It captures the result on a rising clock edge whenever a load enable is high. This lets a source-to-destination register transfer through the unit finish in one clock. The two upper select bits pick the result class: `00` arithmetic, `01` logic, `10` shift toward the LSB, `11` shift toward the MSB. The carry input takes part in choosing among the arithmetic operations.

Top module: `alsu_top`

## Requirements
- R1: With sel[3:2]=00, f equals (a + y + cin) mod 2^N, where y is 0 for sel[1:0]=00, b for 01, the bitwise inverse of b for 10 and all ones for 11. This yields a, a+1, a+b, a+b+1, a-b-1, a-b, a-1 and a.
- R2: With sel[3:2]=00, cout equals bit N of the unbounded sum a + y + cin.
- R3: With sel[3:2]=01, f is a AND b for sel[1:0]=00, a OR b for 01, a XOR b for 10, and the inverse of a for 11.
- R4: In logic and shift classes (sel[3:2] not 00), cin has no effect on f and cout is 0.
- R5: With sel[3:2]=10, f[i] equals a[i+1] for i < N-1, and f[N-1] equals ser_msb_in.
- R6: With sel[3:2]=11, f[i] equals a[i-1] for i > 0, and f[0] equals ser_lsb_in.
- R7: In both shift classes, sel[1:0] and cin have no effect on f.
- R8: On a rising clk edge with rst low, dst_q takes the value f had before the edge if ld_en is high. Otherwise dst_q keeps its value.
- R9: On a rising clk edge with rst high, dst_q becomes 0 regardless of ld_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the destination register |
| rst | input | 1 | Synchronous active-high reset of the destination register |
| ld_en | input | 1 | Load enable of the destination register |
| a | input | N | First operand, also the shift source |
| b | input | N | Second operand |
| sel | input | 4 | Function select; [3:2] result class, [1:0] operation within the class |
| cin | input | 1 | Carry into bit 0, used to select arithmetic operations |
| ser_msb_in | input | 1 | Bit entering the MSB on a shift toward the LSB (tie 0 for a zero fill) |
| ser_lsb_in | input | 1 | Bit entering the LSB on a shift toward the MSB (tie 0 for a zero fill) |
| f | output | N | Combinational result |
| cout | output | 1 | Combinational carry out of the adder chain, 0 outside arithmetic class |
| dst_q | output | N | Destination register |

## Verification
f and cout are combinational, so they are due in the same cycle the operands and select change. The bench applies each combination and samples one nanosecond later, before any clock edge matters. dst_q is due one rising edge after ld_en or rst is sampled high. The bench therefore drives at a falling edge and compares at the following falling edge, which places exactly one rising edge between stimulus and sample. The combinational sweep covers every select, carry and serial-in value over all operand pairs of a 4-bit instance.

// File: rtl/alsu_pkg.sv
package alsu_pkg;
  typedef enum logic [1:0] {
    CLS_ARITH = 2'b00,
    CLS_LOGIC = 2'b01,
    CLS_SHR   = 2'b10,
    CLS_SHL   = 2'b11
  } alsu_cls_e;

  typedef enum logic [1:0] {
    YSRC_ZERO = 2'b00,
    YSRC_B    = 2'b01,
    YSRC_NOTB = 2'b10,
    YSRC_ONES = 2'b11
  } alsu_ysrc_e;

  typedef enum logic [1:0] {
    LOP_AND = 2'b00,
    LOP_OR  = 2'b01,
    LOP_XOR = 2'b10,
    LOP_NOT = 2'b11
  } alsu_lop_e;
endpackage

// File: rtl/alsu_arith.sv
module alsu_arith
  import alsu_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  alsu_ysrc_e   ysrc,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);
  logic [N:0] carry;
  assign carry[0] = cin;

  for (genvar i = 0; i < N; i++) begin : g_stage
    logic y_bit;
    always_comb begin
      unique case (ysrc)
        YSRC_ZERO: y_bit = 1'b0;
        YSRC_B:    y_bit = b[i];
        YSRC_NOTB: y_bit = ~b[i];
        default:   y_bit = 1'b1;
      endcase
    end
    assign sum[i]     = a[i] ^ y_bit ^ carry[i];
    assign carry[i+1] = (a[i] & y_bit) | (carry[i] & (a[i] ^ y_bit));
  end

  assign cout = carry[N];
endmodule

// File: rtl/alsu_logic.sv
module alsu_logic
  import alsu_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  alsu_lop_e    op,
  output logic [N-1:0] res
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      unique case (op)
        LOP_AND: res[i] = a[i] & b[i];
        LOP_OR:  res[i] = a[i] | b[i];
        LOP_XOR: res[i] = a[i] ^ b[i];
        default: res[i] = ~a[i];
      endcase
    end
  end
endmodule

// File: rtl/alsu_outmux.sv
module alsu_outmux
  import alsu_pkg::*;
#(
  parameter int N = 8
) (
  input  alsu_cls_e    cls,
  input  logic [N-1:0] a,
  input  logic [N-1:0] arith,
  input  logic [N-1:0] logic_r,
  input  logic         ser_msb_in,
  input  logic         ser_lsb_in,
  output logic [N-1:0] f
);
  localparam int EW = N + 2;
  logic [EW-1:0] ext;
  assign ext = {ser_msb_in, a, ser_lsb_in};

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      unique case (cls)
        CLS_ARITH: f[i] = arith[i];
        CLS_LOGIC: f[i] = logic_r[i];
        CLS_SHR:   f[i] = ext[i+2];
        default:   f[i] = ext[i];
      endcase
    end
  end
endmodule

// File: rtl/alsu_top.sv
module alsu_top
  import alsu_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_en,
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic [3:0]   sel,
  input  logic         cin,
  input  logic         ser_msb_in,
  input  logic         ser_lsb_in,
  output logic [N-1:0] f,
  output logic         cout,
  output logic [N-1:0] dst_q
);
  alsu_cls_e  cls;
  logic [N-1:0] arith_sum;
  logic [N-1:0] logic_res;
  logic         arith_cout;

  assign cls = alsu_cls_e'(sel[3:2]);

  alsu_arith #(.N(N)) u_arith (
    .a    (a),
    .b    (b),
    .ysrc (alsu_ysrc_e'(sel[1:0])),
    .cin  (cin),
    .sum  (arith_sum),
    .cout (arith_cout)
  );

  alsu_logic #(.N(N)) u_logic (
    .a   (a),
    .b   (b),
    .op  (alsu_lop_e'(sel[1:0])),
    .res (logic_res)
  );

  alsu_outmux #(.N(N)) u_mux (
    .cls        (cls),
    .a          (a),
    .arith      (arith_sum),
    .logic_r    (logic_res),
    .ser_msb_in (ser_msb_in),
    .ser_lsb_in (ser_lsb_in),
    .f          (f)
  );

  assign cout = (cls == CLS_ARITH) ? arith_cout : 1'b0;

  always_ff @(posedge clk) begin
    if (rst)        dst_q <= '0;
    else if (ld_en) dst_q <= f;
  end
endmodule

// File: rtl/alsu_chk.sv
module alsu_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         ld_en,
  input logic [N-1:0] a,
  input logic [3:0]   sel,
  input logic         ser_msb_in,
  input logic         ser_lsb_in,
  input logic [N-1:0] f,
  input logic         cout,
  input logic [N-1:0] dst_q
);
  AST_LOAD_TAKES_F: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> dst_q == $past(f)); // R8
  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    !ld_en |=> $stable(dst_q)); // R8
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> dst_q == '0); // R9
  AST_COUT_ZERO_NONARITH: assert property (@(posedge clk) disable iff (rst)
    sel[3:2] != 2'b00 |-> !cout); // R4
  AST_SHR_FILL: assert property (@(posedge clk) disable iff (rst)
    sel[3:2] == 2'b10 |-> (f[N-1] == ser_msb_in && f[N-2:0] == a[N-1:1])); // R5
  AST_SHL_FILL: assert property (@(posedge clk) disable iff (rst)
    sel[3:2] == 2'b11 |-> (f[0] == ser_lsb_in && f[N-1:1] == a[N-2:0])); // R6
endmodule

bind alsu_top alsu_chk #(.N(N)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ld_en      (ld_en),
  .a          (a),
  .sel        (sel),
  .ser_msb_in (ser_msb_in),
  .ser_lsb_in (ser_lsb_in),
  .f          (f),
  .cout       (cout),
  .dst_q      (dst_q)
);

// File: tb/sim_alsu_top.sv
`timescale 1ns/1ps
module sim_alsu_top;
  localparam int W = 4;
  localparam int WD_CYCLES = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_en = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [3:0] sel = '0;
  logic cin = 1'b0, smsb = 1'b0, slsb = 1'b0;
  logic [W-1:0] f, dst_q;
  logic cout;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alsu_top #(.N(W)) u0 (
    .clk(clk), .rst(rst), .ld_en(ld_en), .a(a), .b(b), .sel(sel), .cin(cin),
    .ser_msb_in(smsb), .ser_lsb_in(slsb), .f(f), .cout(cout), .dst_q(dst_q)
  );

  function automatic logic [W:0] model(input logic [W-1:0] ma, mb,
                                       input logic [3:0] ms,
                                       input logic mc, mr, ml);
    logic [W-1:0] y;
    logic [W:0] r;
    case (ms[3:2])
      2'b00: begin
        case (ms[1:0])
          2'b00: y = '0;
          2'b01: y = mb;
          2'b10: y = ~mb;
          default: y = '1;
        endcase
        r = {1'b0, ma} + {1'b0, y} + (W+1)'(mc);
      end
      2'b01: begin
        case (ms[1:0])
          2'b00: r = {1'b0, ma & mb};
          2'b01: r = {1'b0, ma | mb};
          2'b10: r = {1'b0, ma ^ mb};
          default: r = {1'b0, ~ma};
        endcase
      end
      2'b10: r = {1'b0, mr, ma[W-1:1]};
      default: r = {1'b0, ma[W-2:0], ml};
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: sel=%b cin=%b a=%h b=%h actual=%h expected=%h",
               req, sel, cin, a, b, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    string tag;
    logic [W:0] e;
    // R9: reset state, with load requested at the same time
    ld_en = 1'b1;
    a = 4'hA;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset", {1'b0, dst_q}, '0);
    rst = 1'b0;
    ld_en = 1'b0;
    @(negedge clk);

    // R1..R7: exhaustive combinational sweep, sampled 1 ns after drive
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 2; c++) begin
        for (int sr = 0; sr < 4; sr++) begin
          for (int ia = 0; ia < (1 << W); ia++) begin
            for (int ib = 0; ib < (1 << W); ib++) begin
              sel = 4'(s); cin = c[0]; smsb = sr[1]; slsb = sr[0];
              a = W'(ia); b = W'(ib);
              #1;
              e = model(a, b, sel, cin, smsb, slsb);
              case (sel[3:2])
                2'b00: tag = "R1/R2 arith";
                2'b01: tag = "R3/R4 logic";
                2'b10: tag = "R5/R7/R4 shift right";
                default: tag = "R6/R7/R4 shift left";
              endcase
              check(tag, {cout, f}, e);
            end
          end
        end
      end
    end

    // R8: load through the register, due one rising edge later
    @(negedge clk);
    smsb = 1'b0; slsb = 1'b0;
    a = 4'h9; b = 4'h3; sel = 4'b0001; cin = 1'b0; ld_en = 1'b1;
    e = model(a, b, sel, cin, 1'b0, 1'b0);
    @(negedge clk);
    check("R8 load A+B", {1'b0, dst_q}, {1'b0, e[W-1:0]});
    a = 4'hF; sel = 4'b1100;
    e = model(a, b, sel, cin, 1'b0, 1'b0);
    @(negedge clk);
    check("R8 load shl", {1'b0, dst_q}, {1'b0, e[W-1:0]});
    // R8: hold with ld_en low while inputs change
    ld_en = 1'b0; a = 4'h1; sel = 4'b0100;
    @(negedge clk);
    check("R8 hold", {1'b0, dst_q}, {1'b0, e[W-1:0]});
    // R9: reset wins over load
    rst = 1'b1; ld_en = 1'b1;
    @(negedge clk);
    check("R9 reset over load", {1'b0, dst_q}, '0);
    rst = 1'b0; ld_en = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule